// File: doc/BRIEF.md
# I2C Status Flag Tracker

This block watches an already sampled two-wire bus (clock line and data line) together with the strobes of the controller that owns it. From these it keeps three status flags: one reporting that the first byte after a START carried this node's own 7-bit address, one reporting the transfer direction (1 = this node transmits), and one reporting that the receiver pulled the data line low on the acknowledge clock. It also produces an output enable for the serial data driver that follows the direction flag once the address byte is over.

Internally a three-state byte tracker (`ST_IDLE`, `ST_FIRST`, `ST_NEXT`) counts bus clocks from 1 to 9 within each byte and knows whether it is in the address byte. Transitions:
- `ST_IDLE -> ST_FIRST`: a START is seen.
- `ST_FIRST -> ST_NEXT`: the rising clock edge after the 9th clock, which begins the second byte.
- any state `-> ST_FIRST`: a repeated START, with the clock count reset to zero.
- any state `-> ST_IDLE`: a STOP, or `enable` low.

A flag update module applies each flag's own set and clear rules. A clear always beats a set that falls in the same cycle.

Top module: `i2c_flag_tracker`

## Requirements
- R1: After reset, `addr_match`, `dir_tx`, `ack_seen` and `sda_oe` are all 0.
- R2: A START is SDA falling while SCL stays high, and a STOP is SDA rising while SCL stays high. Bus clocks are counted only after a START, so clock pulses that follow a STOP set no flag.
- R3: `addr_match` goes to 1 on the rising edge of the 8th clock of the first byte when the seven bits sent MSB first on clocks 1 to 7 equal `own_addr`. It stays 0 on a mismatch.
- R4: `addr_match` returns to 0 on a START or a STOP.
- R5: A `rel_comm` pulse, or `enable` going from 1 to 0, returns `addr_match`, `dir_tx`, `ack_seen` and `sda_oe` to 0.
- R6: With `master_mode`=1, a `start_gen` pulse sets `dir_tx` to 1. If the first byte's 8th bit (read/write) is 1, `dir_tx` then goes to 0. If that bit is 0, `dir_tx` stays 1.
- R7: With `master_mode`=0, a detected START sets `dir_tx` to 0, and a 1 in the first byte's 8th bit sets it to 1.
- R8: `dir_tx` returns to 0 on a STOP, a `wait_rel` pulse, or a 0-to-1 change of `arb_lost`.
- R9: `sda_oe` is 1 only while `dir_tx` is 1 and the falling edge of the first byte's 9th clock has passed. A `wait_rel` pulse after the 9th clock clears `dir_tx` and `sda_oe`.
- R10: `ack_seen` goes to 1 when SDA is 0 at the rising edge of the 9th clock, and stays 0 when SDA is 1.
- R11: `ack_seen` returns to 0 at the first rising clock edge of the next byte and on a STOP.
- R12: When a set and a clear of a flag fall in the same cycle, the clear wins.
- R13: A repeated START restarts the clock count, so the byte after it is treated as a fresh address byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scl_i | input | 1 | Sampled bus clock line |
| sda_i | input | 1 | Sampled bus data line |
| own_addr | input | 7 | This node's slave address |
| master_mode | input | 1 | 1 = node acts as master, 0 = slave |
| start_gen | input | 1 | One-cycle pulse: the controller issued a START |
| enable | input | 1 | Block enable; a falling edge clears all flags |
| rel_comm | input | 1 | Pulse: drop out of the current transfer |
| wait_rel | input | 1 | Pulse: release the wait state |
| arb_lost | input | 1 | Arbitration-lost flag (level) |
| addr_match | output | 1 | Own address was received |
| dir_tx | output | 1 | 1 = this node transmits |
| ack_seen | output | 1 | Acknowledge was detected |
| sda_oe | output | 1 | Output enable for the data line driver |

## Verification
The main sweep sends every one of the 128 possible address bytes in both master and slave mode. The read/write bit and the acknowledge bit are varied from the address bits, so the match comparison, the two opposite direction rules and the acknowledge sampling are all tested against both polarities. Flags are checked after the 7th, 8th and 9th clocks and after the first clock of the next byte. This separates an update that comes one clock early or late from one on the correct edge. Directed sequences then cover the clear strobes, a clear that overlaps a set, clocks with no START, and a repeated START in the middle of a byte.

// File: rtl/i2c_flag_pkg.sv
package i2c_flag_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FIRST = 2'd1,
        ST_NEXT  = 2'd2
    } byte_state_e;
endpackage

// File: rtl/i2c_bus_events.sv
module i2c_bus_events (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic scl_q;
    logic sda_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_q <= 1'b1;
            sda_q <= 1'b1;
        end else begin
            scl_q <= scl_i;
            sda_q <= sda_i;
        end
    end

    always_comb begin
        scl_rise  = scl_i & ~scl_q;
        scl_fall  = ~scl_i & scl_q;
        start_det = scl_i & scl_q & sda_q & ~sda_i;
        stop_det  = scl_i & scl_q & ~sda_q & sda_i;
    end
endmodule

// File: rtl/i2c_byte_fsm.sv
module i2c_byte_fsm
    import i2c_flag_pkg::*;
#(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              enable,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr,
    output logic              rise_rw,
    output logic              addr_hit,
    output logic              rise_ack,
    output logic              rise_next,
    output logic              fall_ack_first
);
    localparam int RW_CLK  = ADDR_W + 1;
    localparam int ACK_CLK = ADDR_W + 2;
    localparam int CNT_W   = $clog2(ACK_CLK + 1);
    localparam logic [CNT_W-1:0] C_ADDR = CNT_W'(ADDR_W);
    localparam logic [CNT_W-1:0] C_RW   = CNT_W'(RW_CLK);
    localparam logic [CNT_W-1:0] C_ACK  = CNT_W'(ACK_CLK);
    localparam logic [CNT_W-1:0] C_ONE  = CNT_W'(1);

    byte_state_e       state_q, state_n;
    logic [CNT_W-1:0]  cnt_q;
    logic [ADDR_W-1:0] shreg_q;
    logic              busy;

    assign busy = (state_q != ST_IDLE);

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_n;
    end

    // next state
    always_comb begin
        state_n = state_q;
        if (!enable) begin
            state_n = ST_IDLE;
        end else if (start_det) begin
            state_n = ST_FIRST;
        end else if (stop_det) begin
            state_n = ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE:  state_n = ST_IDLE;
                ST_FIRST: if (scl_rise && cnt_q == C_ACK) state_n = ST_NEXT;
                ST_NEXT:  state_n = ST_NEXT;
                default:  state_n = ST_IDLE;
            endcase
        end
    end

    // clock counter and address shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= '0;
            shreg_q <= '0;
        end else if (!enable || start_det || stop_det) begin
            cnt_q   <= '0;
            shreg_q <= '0;
        end else if (busy && scl_rise) begin
            cnt_q <= (cnt_q == C_ACK) ? C_ONE : cnt_q + C_ONE;
            if (state_q == ST_FIRST && cnt_q < C_ADDR)
                shreg_q <= {shreg_q[ADDR_W-2:0], sda_i};
        end
    end

    // event outputs
    always_comb begin
        rise_rw        = scl_rise && state_q == ST_FIRST && cnt_q == C_ADDR;
        addr_hit       = rise_rw && (shreg_q == own_addr);
        rise_ack       = scl_rise && busy && cnt_q == C_RW;
        rise_next      = scl_rise && busy && cnt_q == C_ACK;
        fall_ack_first = scl_fall && state_q == ST_FIRST && cnt_q == C_ACK;
    end

    assert_cnt_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= C_ACK);
    assert_idle_no_count_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE) |-> (cnt_q == '0));
    assert_restart_R13: assert property (@(posedge clk) disable iff (!rst_n)
        (enable && start_det) |=> (state_q == ST_FIRST && cnt_q == '0));
endmodule

// File: rtl/i2c_status_flags.sv
module i2c_status_flags (
    input  logic clk,
    input  logic rst_n,
    input  logic enable,
    input  logic master_mode,
    input  logic start_gen,
    input  logic rel_comm,
    input  logic wait_rel,
    input  logic arb_lost,
    input  logic start_det,
    input  logic stop_det,
    input  logic rise_rw,
    input  logic addr_hit,
    input  logic sda_i,
    input  logic rise_ack,
    input  logic rise_next,
    input  logic fall_ack_first,
    output logic addr_match,
    output logic dir_tx,
    output logic ack_seen,
    output logic sda_oe
);
    logic en_q, arb_q;
    logic am_q, dir_q, ack_q, ph_q;
    logic am_n, dir_n, ack_n, ph_n;
    logic clr_all, arb_rise;

    always_comb begin
        clr_all  = rel_comm | (en_q & ~enable);
        arb_rise = arb_lost & ~arb_q;

        am_n = am_q;
        if (enable && addr_hit) am_n = 1'b1;
        if (clr_all || start_det || stop_det) am_n = 1'b0;

        dir_n = dir_q;
        if (enable) begin
            if (master_mode) begin
                if (start_gen) dir_n = 1'b1;
                if (rise_rw && sda_i) dir_n = 1'b0;
            end else begin
                if (start_det) dir_n = 1'b0;
                if (rise_rw && sda_i) dir_n = 1'b1;
            end
        end
        if (clr_all || stop_det || wait_rel || arb_rise) dir_n = 1'b0;

        ack_n = ack_q;
        if (enable && rise_ack && !sda_i) ack_n = 1'b1;
        if (clr_all || stop_det || rise_next) ack_n = 1'b0;

        ph_n = ph_q;
        if (enable && fall_ack_first) ph_n = 1'b1;
        if (clr_all || start_det || stop_det) ph_n = 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q  <= 1'b0;
            arb_q <= 1'b0;
            am_q  <= 1'b0;
            dir_q <= 1'b0;
            ack_q <= 1'b0;
            ph_q  <= 1'b0;
        end else begin
            en_q  <= enable;
            arb_q <= arb_lost;
            am_q  <= am_n;
            dir_q <= dir_n;
            ack_q <= ack_n;
            ph_q  <= ph_n;
        end
    end

    always_comb begin
        addr_match = am_q;
        dir_tx     = dir_q;
        ack_seen   = ack_q;
        sda_oe     = dir_q & ph_q;
    end

    assert_match_origin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(addr_match) |-> $past(addr_hit));
    assert_stop_clears_R11: assert property (@(posedge clk) disable iff (!rst_n)
        stop_det |=> (!addr_match && !dir_tx && !ack_seen)); // also R4, R8
    assert_release_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        rel_comm |=> (!addr_match && !dir_tx && !ack_seen && !sda_oe));
    assert_arb_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(arb_lost) |=> !dir_tx);
    assert_wait_release_R9: assert property (@(posedge clk) disable iff (!rst_n)
        wait_rel |=> (!dir_tx && !sda_oe));
    assert_ack_origin_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ack_seen) |-> $past(rise_ack && !sda_i));
endmodule

// File: rtl/i2c_flag_tracker.sv
module i2c_flag_tracker #(
    parameter int ADDR_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic [ADDR_W-1:0] own_addr,
    input  logic              master_mode,
    input  logic              start_gen,
    input  logic              enable,
    input  logic              rel_comm,
    input  logic              wait_rel,
    input  logic              arb_lost,
    output logic              addr_match,
    output logic              dir_tx,
    output logic              ack_seen,
    output logic              sda_oe
);
    logic scl_rise, scl_fall, start_det, stop_det;
    logic rise_rw, addr_hit, rise_ack, rise_next, fall_ack_first;

    i2c_bus_events u_events (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    i2c_byte_fsm #(.ADDR_W(ADDR_W)) u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable         (enable),
        .scl_rise       (scl_rise),
        .scl_fall       (scl_fall),
        .start_det      (start_det),
        .stop_det       (stop_det),
        .sda_i          (sda_i),
        .own_addr       (own_addr),
        .rise_rw        (rise_rw),
        .addr_hit       (addr_hit),
        .rise_ack       (rise_ack),
        .rise_next      (rise_next),
        .fall_ack_first (fall_ack_first)
    );

    i2c_status_flags u_flags (
        .clk            (clk),
        .rst_n          (rst_n),
        .enable         (enable),
        .master_mode    (master_mode),
        .start_gen      (start_gen),
        .rel_comm       (rel_comm),
        .wait_rel       (wait_rel),
        .arb_lost       (arb_lost),
        .start_det      (start_det),
        .stop_det       (stop_det),
        .rise_rw        (rise_rw),
        .addr_hit       (addr_hit),
        .sda_i          (sda_i),
        .rise_ack       (rise_ack),
        .rise_next      (rise_next),
        .fall_ack_first (fall_ack_first),
        .addr_match     (addr_match),
        .dir_tx         (dir_tx),
        .ack_seen       (ack_seen),
        .sda_oe         (sda_oe)
    );
endmodule

// File: tb/test_i2c_flag_tracker.sv
`timescale 1ns/1ps
module test_i2c_flag_tracker;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1, sda = 1'b1;
    logic [6:0] own = 7'h5A;
    logic       master_mode = 1'b0, start_gen = 1'b0, enable = 1'b1;
    logic       rel_comm = 1'b0, wait_rel = 1'b0, arb_lost = 1'b0;
    logic       addr_match, dir_tx, ack_seen, sda_oe;
    int         errors = 0;
    int         checks = 0;

    always #4 clk = ~clk;

    i2c_flag_tracker i_i2c_flag_tracker (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda), .own_addr(own),
        .master_mode(master_mode), .start_gen(start_gen), .enable(enable),
        .rel_comm(rel_comm), .wait_rel(wait_rel), .arb_lost(arb_lost),
        .addr_match(addr_match), .dir_tx(dir_tx), .ack_seen(ack_seen), .sda_oe(sda_oe)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0b expected=%0b", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic bus_start();
        sda = 1'b1; wait_n(2);
        scl = 1'b1; wait_n(2);
        sda = 1'b0; wait_n(2);
        scl = 1'b0; wait_n(2);
    endtask

    task automatic bus_stop();
        scl = 1'b0; sda = 1'b0; wait_n(2);
        scl = 1'b1; wait_n(2);
        sda = 1'b1; wait_n(2);
    endtask

    task automatic bus_bit(input logic b);
        scl = 1'b0; sda = b; wait_n(2);
        scl = 1'b1; wait_n(2);
        scl = 1'b0; wait_n(2);
    endtask

    task automatic pulse_start_gen();
        start_gen = 1'b1; wait_n(1);
        start_gen = 1'b0; wait_n(1);
    endtask

    task automatic send_addr(input logic [6:0] a, input int nbits);
        for (int i = 0; i < nbits; i++) bus_bit(a[6 - i]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic rw, ackb, exp_dir;
        wait_n(3);
        chk("R1 addr_match", addr_match, 1'b0);
        chk("R1 dir_tx", dir_tx, 1'b0);
        chk("R1 ack_seen", ack_seen, 1'b0);
        chk("R1 sda_oe", sda_oe, 1'b0);
        rst_n = 1'b1;
        wait_n(2);

        // sweep: both modes, every address
        for (int m = 0; m < 2; m++) begin
            master_mode = logic'(m);
            for (int ai = 0; ai < 128; ai++) begin
                logic [6:0] a;
                a = 7'(ai);
                rw   = a[2] ^ a[5];
                ackb = a[1];
                exp_dir = (m == 1) ? ~rw : rw;
                bus_start();
                if (m == 1) begin
                    pulse_start_gen();
                    chk("R6 dir after start_gen", dir_tx, 1'b1);
                end else begin
                    chk("R7 dir after START", dir_tx, 1'b0);
                end
                send_addr(a, 7);
                chk("R3 no match before clk8", addr_match, 1'b0);
                bus_bit(rw);
                chk("R3 match at clk8", addr_match, a == own);
                chk(m == 1 ? "R6 master dir" : "R7 slave dir", dir_tx, exp_dir);
                chk("R9 oe before clk9", sda_oe, 1'b0);
                bus_bit(ackb);
                chk("R10 ack at clk9", ack_seen, ~ackb);
                chk("R9 oe after clk9", sda_oe, exp_dir);
                bus_bit(1'b1);
                chk("R11 ack cleared next byte", ack_seen, 1'b0);
                bus_stop();
                chk("R4 match cleared by STOP", addr_match, 1'b0);
                chk("R8 dir cleared by STOP", dir_tx, 1'b0);
                chk("R9 oe cleared by STOP", sda_oe, 1'b0);
            end
        end
        master_mode = 1'b0;

        // R2: clocks without START
        send_addr(own, 7); bus_bit(1'b1); bus_bit(1'b0);
        chk("R2 no match without START", addr_match, 1'b0);
        chk("R2 no dir without START", dir_tx, 1'b0);
        chk("R2 no ack without START", ack_seen, 1'b0);
        bus_stop();

        // R9/R11: wait release and STOP on ack
        bus_start(); send_addr(own, 7); bus_bit(1'b1); bus_bit(1'b0);
        chk("R9 oe driven", sda_oe, 1'b1);
        wait_rel = 1'b1; wait_n(1); wait_rel = 1'b0; wait_n(1);
        chk("R9 wait_rel dir", dir_tx, 1'b0);
        chk("R9 wait_rel oe", sda_oe, 1'b0);
        chk("R11 ack kept before STOP", ack_seen, 1'b1);
        bus_stop();
        chk("R11 ack cleared by STOP", ack_seen, 1'b0);

        // R5: release strobe
        bus_start(); send_addr(own, 7); bus_bit(1'b1); bus_bit(1'b0);
        rel_comm = 1'b1; wait_n(1); rel_comm = 1'b0; wait_n(1);
        chk("R5 rel match", addr_match, 1'b0);
        chk("R5 rel dir", dir_tx, 1'b0);
        chk("R5 rel ack", ack_seen, 1'b0);
        chk("R5 rel oe", sda_oe, 1'b0);
        bus_stop();

        // R5: enable falling
        bus_start(); send_addr(own, 7); bus_bit(1'b1); bus_bit(1'b0);
        enable = 1'b0; wait_n(2);
        chk("R5 enable match", addr_match, 1'b0);
        chk("R5 enable dir", dir_tx, 1'b0);
        chk("R5 enable ack", ack_seen, 1'b0);
        chk("R5 enable oe", sda_oe, 1'b0);
        enable = 1'b1; wait_n(2);
        bus_stop();

        // R8: arbitration loss
        master_mode = 1'b1;
        bus_start(); pulse_start_gen();
        chk("R8 dir before arb", dir_tx, 1'b1);
        arb_lost = 1'b1; wait_n(2);
        chk("R8 arb clears dir", dir_tx, 1'b0);
        arb_lost = 1'b0; wait_n(1);
        bus_stop();
        master_mode = 1'b0;

        // R12: clear overlapping set
        bus_start(); send_addr(own, 7);
        rel_comm = 1'b1; bus_bit(1'b1); rel_comm = 1'b0;
        chk("R12 clear beats match set", addr_match, 1'b0);
        chk("R12 clear beats dir set", dir_tx, 1'b0);
        bus_stop();

        // R13: repeated START mid-byte
        bus_start(); send_addr(7'h00, 4);
        bus_start(); send_addr(own, 7);
        chk("R13 no early match", addr_match, 1'b0);
        bus_bit(1'b0);
        chk("R13 match after restart", addr_match, 1'b1);
        bus_start();
        chk("R4 match cleared by START", addr_match, 1'b0);
        bus_stop();

        $display("  Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule